// File: doc/BRIEF.md
# Asymmetric Integer Issue-Port Steering

This block sits between integer rename and the execution ports. Each cycle it receives a group of up to six decoded micro-ops, each tagged with a class, and places each accepted one into one of six private scheduling queues. Ports 0 to 3 feed ALUs and ports 4 and 5 feed address-generation units. The ALUs do not all offer the same functions. Only two take branches, one takes multiplies and one takes CRC, so every placement is checked against a per-class capability mask. Among the legal ports the least occupied queue is chosen.

Each queue keeps its entries in age order and sends one micro-op per cycle to its port. It picks the oldest entry whose readiness input is set. Dispatch stays in order: the first micro-op that cannot be placed holds itself and every younger one in the group. A flush input empties every queue in one cycle.

Top module: `int_port_steer`

## Requirements
- R1: The class code selects the legal ports: 1 (branch) goes to ports 0 or 1, 2 (multiply) to port 2 only, 3 (CRC) to port 3 only, 4 (address) to ports 4 or 5, and 0 or any code 5 to 7 (simple ALU) to ports 0 to 3. For each accepted slot s, disp_port_o[3s+:3] gives the chosen port.
- R2: Among the legal queues that have a free entry, the one with the fewest entries is chosen, with ties going to the lowest port index. Placements made by older slots in the same group count toward occupancy.
- R3: A slot whose legal queues are all full is not accepted, and no younger slot is accepted either. A queue never holds more than 14 entries.
- R4: At most two branches are accepted per cycle. A third branch, and every slot younger than it, is held.
- R5: in_ready_o[s] is high only for valid slots that were accepted. Invalid slots are skipped and do not block. The accepted slots are always a prefix of the valid slots.
- R6: Each queue p issues at most one micro-op per cycle: the oldest entry whose readiness bit ent_rdy_i[14p+i] is set, where i counts from 0 at the oldest entry. Its payload appears on iss_data_o[16p+:16] with iss_valid_o[p] high.
- R7: An issued entry leaves its queue in the same cycle. Free space is judged from occupancy at the start of the cycle, so the freed entry can be used from the next cycle on.
- R8: While flush_i is high, nothing is accepted and nothing issues, and every queue is empty from the next cycle. Dispatch resumes in that next cycle.
- R9: After reset all queues are empty and nothing issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty all queues |
| in_valid_i | input | 6 | Slot valid, slot 0 oldest |
| in_class_i | input | 18 | 3-bit class per slot |
| in_data_i | input | 96 | 16-bit payload per slot |
| in_ready_o | output | 6 | Slot accepted this cycle |
| disp_port_o | output | 18 | 3-bit chosen port per slot |
| ent_rdy_i | input | 84 | Readiness per queue position, 14 per port |
| iss_valid_o | output | 6 | Port issues this cycle |
| iss_data_o | output | 96 | 16-bit issued payload per port |

## Verification
Two things can happen to one queue in the same cycle: an entry can issue and leave while new micro-ops are appended behind it, and this can coincide with a queue that is full. The bench provokes this by filling the multiply queue to its limit and then raising the readiness bit of its oldest entry while another multiply is offered. It expects the oldest payload to issue, the offered multiply to be refused in that cycle and accepted in the next. Random phases with sparse readiness keep queues near full while issue and append overlap. A bench reference model of the queues judges every issued payload and every acceptance.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    UC_ALU = 3'd0,
    UC_BR  = 3'd1,
    UC_MUL = 3'd2,
    UC_CRC = 3'd3,
    UC_AGU = 3'd4
  } uop_cls_e;
endpackage

// File: rtl/port_pick.sv
module port_pick #(
  parameter int N_PORTS = 6,
  parameter int DEPTH   = 14,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int PW     = $clog2(N_PORTS)
) (
  input  logic [N_PORTS-1:0]         elig_i,
  input  logic [N_PORTS-1:0][CW-1:0] occ_i,
  output logic                       found_o,
  output logic [PW-1:0]              sel_o
);
  logic [CW-1:0] best;

  // strict less-than keeps the lowest index on ties
  always_comb begin
    found_o = 1'b0;
    sel_o   = '0;
    best    = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (elig_i[p] && (occ_i[p] < CW'(DEPTH)) && (!found_o || (occ_i[p] < best))) begin
        found_o = 1'b1;
        sel_o   = PW'(p);
        best    = occ_i[p];
      end
    end
  end
endmodule

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import steer_pkg::*;
#(
  parameter int N_SLOTS = 6,
  parameter int N_PORTS = 6,
  parameter int DEPTH   = 14,
  parameter int MAX_BR  = 2,
  parameter logic [N_PORTS-1:0] ALU_MASK = 6'b001111,
  parameter logic [N_PORTS-1:0] AGU_MASK = 6'b110000,
  parameter logic [N_PORTS-1:0] BR_MASK  = 6'b000011,
  parameter logic [N_PORTS-1:0] MUL_MASK = 6'b000100,
  parameter logic [N_PORTS-1:0] CRC_MASK = 6'b001000,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(N_PORTS),
  localparam int BW = $clog2(N_SLOTS + 1)
) (
  input  logic                             flush_i,
  input  logic [N_SLOTS-1:0]               valid_i,
  input  logic [N_SLOTS-1:0][CLS_W-1:0]    cls_i,
  input  logic [N_PORTS-1:0][CW-1:0]       occ_i,
  output logic [N_SLOTS-1:0]               acc_o,
  output logic [N_SLOTS-1:0][PW-1:0]       sel_o
);
  logic [N_SLOTS:0]                        blk;
  logic [N_SLOTS:0][BW-1:0]                nbr;
  logic [N_SLOTS:0][N_PORTS-1:0][CW-1:0]   occ_c;

  assign blk[0]   = flush_i;
  assign nbr[0]   = '0;
  assign occ_c[0] = occ_i;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    logic [N_PORTS-1:0] elig;
    logic               found;
    logic               is_br;
    logic               br_ok;

    assign is_br = (cls_i[s] == UC_BR);
    assign elig  = (cls_i[s] == UC_BR)  ? BR_MASK  :
                   (cls_i[s] == UC_MUL) ? MUL_MASK :
                   (cls_i[s] == UC_CRC) ? CRC_MASK :
                   (cls_i[s] == UC_AGU) ? AGU_MASK : ALU_MASK;

    port_pick #(.N_PORTS(N_PORTS), .DEPTH(DEPTH)) u_pick (
      .elig_i (elig),
      .occ_i  (occ_c[s]),
      .found_o(found),
      .sel_o  (sel_o[s])
    );

    assign br_ok      = !is_br || (nbr[s] < BW'(MAX_BR));
    assign acc_o[s]   = valid_i[s] && !blk[s] && found && br_ok;
    assign blk[s+1]   = blk[s] || (valid_i[s] && !acc_o[s]);
    assign nbr[s+1]   = nbr[s] + BW'(acc_o[s] && is_br);

    for (genvar p = 0; p < N_PORTS; p++) begin : g_occ
      assign occ_c[s+1][p] = occ_c[s][p] + CW'(acc_o[s] && (sel_o[s] == PW'(p)));
    end
  end
endmodule

// File: rtl/issue_queue.sv
module issue_queue #(
  parameter int DEPTH  = 14,
  parameter int DATA_W = 16,
  parameter int N_WR   = 6,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic [N_WR-1:0]              wr_en_i,
  input  logic [N_WR-1:0][DATA_W-1:0]  wr_data_i,
  input  logic [DEPTH-1:0]             rdy_i,
  output logic                         iss_valid_o,
  output logic [DATA_W-1:0]            iss_data_o,
  output logic [CW-1:0]                cnt_o
);
  // position 0 is always the oldest entry
  logic [DEPTH-1:0][DATA_W-1:0] ent_q, ent_d;
  logic [CW-1:0]                cnt_q, cnt_d;
  logic                         hit;
  logic [IW-1:0]                k;

  always_comb begin
    hit = 1'b0;
    k   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!hit && (CW'(i) < cnt_q) && rdy_i[i]) begin
        hit = 1'b1;
        k   = IW'(i);
      end
    end
  end

  assign iss_valid_o = hit && !flush_i;
  assign iss_data_o  = ent_q[k];
  assign cnt_o       = cnt_q;

  always_comb begin
    logic [CW-1:0] idx;
    ent_d = ent_q;
    if (hit) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IW'(i) >= k) ent_d[i] = ent_q[i+1];
      end
    end
    idx = cnt_q - CW'(hit);
    for (int s = 0; s < N_WR; s++) begin
      if (wr_en_i[s] && (idx < CW'(DEPTH))) begin
        ent_d[IW'(idx)] = wr_data_i[s];
        idx = idx + 1'b1;
      end
    end
    cnt_d = flush_i ? '0 : idx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ent_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      ent_q <= ent_d;
    end
  end
endmodule

// File: rtl/int_port_steer.sv
module int_port_steer
  import steer_pkg::*;
#(
  parameter int N_SLOTS = 6,
  parameter int N_ALU   = 4,
  parameter int N_AGU   = 2,
  parameter int DEPTH   = 14,
  parameter int DATA_W  = 16,
  parameter int MAX_BR  = 2,
  parameter logic [N_ALU-1:0] BR_ALUS  = 4'b0011,
  parameter logic [N_ALU-1:0] MUL_ALUS = 4'b0100,
  parameter logic [N_ALU-1:0] CRC_ALUS = 4'b1000,
  localparam int N_PORTS = N_ALU + N_AGU,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int PW      = $clog2(N_PORTS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic [N_SLOTS-1:0]           in_valid_i,
  input  logic [N_SLOTS*CLS_W-1:0]     in_class_i,
  input  logic [N_SLOTS*DATA_W-1:0]    in_data_i,
  output logic [N_SLOTS-1:0]           in_ready_o,
  output logic [N_SLOTS*PW-1:0]        disp_port_o,
  input  logic [N_PORTS*DEPTH-1:0]     ent_rdy_i,
  output logic [N_PORTS-1:0]           iss_valid_o,
  output logic [N_PORTS*DATA_W-1:0]    iss_data_o
);
  localparam logic [N_PORTS-1:0] P_ALU = N_PORTS'((1 << N_ALU) - 1);
  localparam logic [N_PORTS-1:0] P_AGU = ~P_ALU;
  localparam logic [N_PORTS-1:0] P_BR  = N_PORTS'(BR_ALUS);
  localparam logic [N_PORTS-1:0] P_MUL = N_PORTS'(MUL_ALUS);
  localparam logic [N_PORTS-1:0] P_CRC = N_PORTS'(CRC_ALUS);

  logic [N_SLOTS-1:0][CLS_W-1:0]  cls;
  logic [N_SLOTS-1:0][DATA_W-1:0] data;
  logic [N_SLOTS-1:0]             acc;
  logic [N_SLOTS-1:0][PW-1:0]     sel;
  logic [N_PORTS-1:0][CW-1:0]     q_cnt;

  assign cls         = in_class_i;
  assign data        = in_data_i;
  assign in_ready_o  = acc;
  assign disp_port_o = sel;

  steer_ctrl #(
    .N_SLOTS (N_SLOTS), .N_PORTS(N_PORTS), .DEPTH(DEPTH), .MAX_BR(MAX_BR),
    .ALU_MASK(P_ALU), .AGU_MASK(P_AGU), .BR_MASK(P_BR),
    .MUL_MASK(P_MUL), .CRC_MASK(P_CRC)
  ) u_steer (
    .flush_i(flush_i),
    .valid_i(in_valid_i),
    .cls_i  (cls),
    .occ_i  (q_cnt),
    .acc_o  (acc),
    .sel_o  (sel)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    logic [N_SLOTS-1:0] wr_en;
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_wr
      assign wr_en[s] = acc[s] && (sel[s] == PW'(p));
    end

    issue_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W), .N_WR(N_SLOTS)) u_q (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flush_i    (flush_i),
      .wr_en_i    (wr_en),
      .wr_data_i  (data),
      .rdy_i      (ent_rdy_i[p*DEPTH +: DEPTH]),
      .iss_valid_o(iss_valid_o[p]),
      .iss_data_o (iss_data_o[p*DATA_W +: DATA_W]),
      .cnt_o      (q_cnt[p])
    );
  end
endmodule

// File: rtl/int_port_steer_chk.sv
module int_port_steer_chk
  import steer_pkg::*;
#(
  parameter int N_SLOTS = 6,
  parameter int N_PORTS = 6,
  parameter int DEPTH   = 14,
  parameter int MAX_BR  = 2,
  parameter logic [N_PORTS-1:0] ALU_MASK = 6'b001111,
  parameter logic [N_PORTS-1:0] AGU_MASK = 6'b110000,
  parameter logic [N_PORTS-1:0] BR_MASK  = 6'b000011,
  parameter logic [N_PORTS-1:0] MUL_MASK = 6'b000100,
  parameter logic [N_PORTS-1:0] CRC_MASK = 6'b001000,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(N_PORTS)
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         flush_i,
  input logic [N_SLOTS-1:0]           in_valid_i,
  input logic [N_SLOTS*CLS_W-1:0]     in_class_i,
  input logic [N_SLOTS-1:0]           in_ready_o,
  input logic [N_SLOTS*PW-1:0]        disp_port_o,
  input logic [N_PORTS-1:0]           iss_valid_o,
  input logic [N_PORTS-1:0][CW-1:0]   q_cnt
);
  function automatic logic legal(logic [CLS_W-1:0] c, logic [PW-1:0] port);
    logic [N_PORTS-1:0] m;
    m = (c == UC_BR)  ? BR_MASK  : (c == UC_MUL) ? MUL_MASK :
        (c == UC_CRC) ? CRC_MASK : (c == UC_AGU) ? AGU_MASK : ALU_MASK;
    return (int'(port) < N_PORTS) && m[port];
  endfunction

  function automatic int br_taken(logic [N_SLOTS-1:0] rd, logic [N_SLOTS*CLS_W-1:0] c);
    int n = 0;
    for (int s = 0; s < N_SLOTS; s++)
      if (rd[s] && (c[s*CLS_W +: CLS_W] == UC_BR)) n++;
    return n;
  endfunction

  function automatic logic prefix_ok(logic [N_SLOTS-1:0] v, logic [N_SLOTS-1:0] rd);
    logic held = 1'b0;
    logic ok   = 1'b1;
    for (int s = 0; s < N_SLOTS; s++) begin
      if (rd[s] && (held || !v[s])) ok = 1'b0;
      if (v[s] && !rd[s]) held = 1'b1;
    end
    return ok;
  endfunction

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    a_r1_port_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_ready_o[s] |-> legal(in_class_i[s*CLS_W +: CLS_W], disp_port_o[s*PW +: PW]));
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_cnt[p] <= CW'(DEPTH));
    a_r6_issue_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
      iss_valid_o[p] |-> (q_cnt[p] != '0));
  end

  a_r4_branch_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken(in_ready_o, in_class_i) <= MAX_BR);

  a_r5_in_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prefix_ok(in_valid_i, in_ready_o));

  a_r8_flush_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> ((in_ready_o == '0) && (iss_valid_o == '0)));

  a_r8_flush_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (q_cnt == '0));
endmodule

bind int_port_steer int_port_steer_chk #(
  .N_SLOTS(N_SLOTS), .N_PORTS(N_PORTS), .DEPTH(DEPTH), .MAX_BR(MAX_BR),
  .ALU_MASK(P_ALU), .AGU_MASK(P_AGU), .BR_MASK(P_BR),
  .MUL_MASK(P_MUL), .CRC_MASK(P_CRC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .flush_i    (flush_i),
  .in_valid_i (in_valid_i),
  .in_class_i (in_class_i),
  .in_ready_o (in_ready_o),
  .disp_port_o(disp_port_o),
  .iss_valid_o(iss_valid_o),
  .q_cnt      (q_cnt)
);

// File: tb/int_port_steer_tb_top.sv
module int_port_steer_tb_top;
  localparam int NS = 6, NP = 6, D = 14, W = 16;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic [NS-1:0]   in_valid = '0, in_ready;
  logic [NS*3-1:0] in_class = '0;
  logic [NS*W-1:0] in_data = '0;
  logic [NS*3-1:0] disp_port;
  logic [NP*D-1:0] ent_rdy = '0;
  logic [NP-1:0]   iss_valid;
  logic [NP*W-1:0] iss_data;

  always #10 clk = ~clk;

  int_port_steer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .in_valid_i(in_valid), .in_class_i(in_class), .in_data_i(in_data),
    .in_ready_o(in_ready), .disp_port_o(disp_port),
    .ent_rdy_i(ent_rdy), .iss_valid_o(iss_valid), .iss_data_o(iss_data)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] mq[NP][D];
  int mc[NP];

  logic [NS-1:0] v;
  logic [2:0]    c[NS];
  logic [15:0]   d[NS];
  logic [NP*D-1:0] rdy;
  logic          fl;

  task automatic chk(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [NP-1:0] elig(logic [2:0] cl);
    case (cl)
      3'd1: return 6'b000011;
      3'd2: return 6'b000100;
      3'd3: return 6'b001000;
      3'd4: return 6'b110000;
      default: return 6'b001111;
    endcase
  endfunction

  task automatic step();
    int occ[NP];
    logic [NS-1:0] ea;
    int ep[NS];
    int ek[NP];
    bit eh[NP];
    bit blk;
    int nb;
    @(negedge clk);
    flush = fl; in_valid = v; ent_rdy = rdy;
    for (int s = 0; s < NS; s++) begin
      in_class[s*3 +: 3] = c[s];
      in_data[s*W +: W]  = d[s];
    end
    #1;
    for (int p = 0; p < NP; p++) begin
      eh[p] = 0; ek[p] = 0;
      for (int i = 0; i < mc[p]; i++)
        if (!eh[p] && rdy[p*D+i]) begin eh[p] = 1; ek[p] = i; end
      chk("R6 issue valid", iss_valid[p], eh[p] && !fl);
      if (eh[p] && !fl) chk("R6 issue data", iss_data[p*W +: W], mq[p][ek[p]]);
      occ[p] = mc[p];
    end
    blk = fl; nb = 0; ea = '0;
    for (int s = 0; s < NS; s++) begin
      ep[s] = 0;
      if (v[s] && !blk) begin
        logic [NP-1:0] m;
        bit f;
        int b;
        m = elig(c[s]); f = 0; b = 0;
        for (int p = 0; p < NP; p++)
          if (m[p] && occ[p] < D && (!f || occ[p] < b)) begin f = 1; b = occ[p]; ep[s] = p; end
        if (f && !(c[s] == 3'd1 && nb >= 2)) begin
          ea[s] = 1; occ[ep[s]]++;
          if (c[s] == 3'd1) nb++;
        end else blk = 1;
      end
    end
    chk("R5 accept vector", in_ready, ea);
    for (int s = 0; s < NS; s++)
      if (ea[s]) begin
        chk("R2 chosen port", disp_port[s*3 +: 3], ep[s]);
        chk("R1 port legal", elig(c[s])[disp_port[s*3 +: 3]], 1);
      end
    if (fl) begin
      for (int p = 0; p < NP; p++) mc[p] = 0;
    end else begin
      for (int p = 0; p < NP; p++)
        if (eh[p]) begin
          for (int i = ek[p]; i < mc[p] - 1; i++) mq[p][i] = mq[p][i+1];
          mc[p]--;
        end
      for (int s = 0; s < NS; s++)
        if (ea[s]) begin mq[ep[s]][mc[ep[s]]] = d[s]; mc[ep[s]]++; end
    end
  endtask

  task automatic set_group(logic [NS-1:0] vv, logic [2:0] cl);
    v = vv;
    for (int s = 0; s < NS; s++) begin c[s] = cl; d[s] = 16'($urandom); end
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int p = 0; p < NP; p++) mc[p] = 0;
    fl = 0; rdy = '0; set_group('0, 3'd0);
    repeat (3) @(negedge clk);
    chk("R9 reset no issue", iss_valid, 0);
    rst_n = 1'b1;

    // R9: empty after reset, even with every readiness bit set
    rdy = '1; set_group('0, 3'd0); step();
    chk("R9 empty queues", iss_valid, 0);

    // R2: spread over ALUs then AGUs
    rdy = '0; set_group(6'h3f, 3'd0); step();
    chk("R2 alu spread", disp_port, {3'd1, 3'd0, 3'd3, 3'd2, 3'd1, 3'd0});
    set_group(6'h3f, 3'd4); step();
    chk("R1 agu spread", disp_port, {3'd5, 3'd4, 3'd5, 3'd4, 3'd5, 3'd4});

    // R8: flush refuses input, queues empty next cycle
    fl = 1; step();
    chk("R8 flush refuses", in_ready, 0);
    fl = 0; rdy = '1; set_group('0, 3'd0); step();
    chk("R8 empty after flush", iss_valid, 0);

    // R3: fill the multiply queue
    rdy = '0;
    set_group(6'h3f, 3'd2); step(); step(); step();
    chk("R3 full queue holds", in_ready, 6'h03);
    // R7: oldest issues while full; offered multiply refused this cycle
    set_group(6'h01, 3'd2); rdy = '0; rdy[2*D] = 1'b1; step();
    chk("R7 issue while full", iss_valid[2], 1);
    chk("R7 freed slot not reused", in_ready, 0);
    rdy = '0; step();
    chk("R7 freed slot next cycle", in_ready, 6'h01);

    fl = 1; step(); fl = 0;

    // R4: branch cap
    set_group(6'h0f, 3'd1); c[3] = 3'd0; step();
    chk("R4 third branch held", in_ready, 6'h03);
    // R5: sparse group
    set_group(6'h2a, 3'd0); step();
    chk("R5 gaps skipped", in_ready, 6'h2a);

    fl = 1; step(); fl = 0;

    for (int n = 0; n < 4000; n++) begin
      v = 6'($urandom);
      for (int s = 0; s < NS; s++) begin c[s] = 3'($urandom); d[s] = 16'($urandom); end
      rdy = {$urandom, $urandom, $urandom} >> 12;
      if ((n / 500) % 2 == 0) rdy = rdy & ({$urandom, $urandom, $urandom} >> 12) & ({$urandom, $urandom, $urandom} >> 12);
      fl = ($urandom % 97) == 0;
      step();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule